// File: doc/BRIEF.md
# Flat Page-Table Address Translator

This block sits between a bus master and memory and turns the master's virtual addresses into physical ones. The mapping is one flat table in memory: word `k` of the table holds the physical page number for the `k`-th page of a configurable virtual window. Pages are 4 KiB. The low 12 address bits pass through unchanged.

Requests arrive on a valid/ready port with an address and a write flag. Only one request is in flight at a time, and every accepted request produces exactly one response pulse. A four-entry fully associative cache of recent translations sits in front of the table walk. On a cache miss the block issues a single memory read for the table word. An access is redirected to a protect page and flagged as a fault in three cases: it falls outside the window, its table word is zero, or translation is switched off. A bypass mode passes addresses straight through.

Software configures the block through a small 32-bit register port. A parameter selects one of two register layouts, and a read-only version field reports which layout is in use.

Top module: `flatmap_iommu`

## Requirements
- R1: For an in-window access with a non-zero table word E, the response address is (E[19:0] << 12) | VA[11:0], and the fault output is low.
- R2: The table read address is (table-base PPN << 12) + 4 × (VPN − first VPN).
- R3: An access is in the window only when first VPN ≤ VPN and VPN − first VPN ≤ range, where both are 20-bit values. The sum first VPN + range is never formed, so it cannot wrap. An out-of-window access faults and issues no memory read.
- R4: A faulting access returns (fallback PPN << 12) | VA[11:0]. In the extended layout, reads use the read fallback PPN at 0x14 and writes use the write fallback PPN at 0x18. In the compact layout, both use 0x14.
- R5: A table word equal to zero faults. Such a word is never cached.
- R6: Config bit 0 (enable) and bit 1 (gate) must both be set for translation. Bit 4 (bypass) takes priority and returns VA unchanged, with no fault and no memory read. Otherwise, with translation off, every access faults.
- R7: The register at 0x00 reports the layout in bits 15:8. A value of 1 means the extended layout: config 0x04, update 0x08, auth 0x0C (plain storage), table base 0x10, read fallback 0x14, write fallback 0x18, first VPN 0x1C, range 0x20. A value of 0 means the compact layout: config merged into 0x00, update 0x04, first VPN 0x08, range 0x0C, table base 0x10, fallback 0x14.
- R8: A cached page responds in the cycle after acceptance and issues no memory read. A miss issues exactly one memory read and responds in the cycle after the read data arrives.
- R9: Writing 0xFFFFFFFF to the update register invalidates every cached translation. Any other value written there has no effect on the cache.
- R10: The cache holds four translations and replaces them in round-robin order. The fifth distinct page filled evicts the first one.
- R11: Every fault response sets a sticky flag at 0x24 bit 0 and records its VPN at 0x28. Writing 1 to 0x24 bit 0 clears the flag, and writing 0 leaves it set.
- R12: While a table walk is in progress, req_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | VA_W | Virtual address |
| req_write | input | 1 | Request is a write |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_pa | output | PA_W | Translated or redirected address |
| resp_fault | output | 1 | Response was redirected to the fallback page |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Table word byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Table word |

## Verification
On every cycle, the embedded properties check four things. Bypass returns the request address untouched. Out-of-window requests never start a walk. A zero table word always yields a fault. Each memory read handshake is followed by silence on the read port. Further properties check that no two cache slots ever match the same VPN, that a flush leaves nothing to hit, and that the fault flag stays set until it is cleared.

Some behaviour depends on sequences of requests, and only the bench scenarios show it: the actual address values, the choice of read or write fallback page, hit and miss latencies, round-robin eviction order, the selective effect of the update key, and the absence of aliasing when the window sits at the top of the VPN space.

// File: rtl/flatmap_pkg.sv
package flatmap_pkg;
   localparam int PAGE_SHIFT = 12;
   localparam logic [31:0] FLUSH_KEY = 32'hFFFF_FFFF;

   typedef enum logic [1:0] {
      WALK_IDLE = 2'd0,
      WALK_REQ  = 2'd1,
      WALK_WAIT = 2'd2
   } walk_state_e;
endpackage

// File: rtl/flatmap_regs.sv
module flatmap_regs
   import flatmap_pkg::*;
#(
   parameter int LAYOUT = 1,
   parameter int VPN_W  = 20,
   parameter int PPN_W  = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [7:0]       addr_i,
   input  logic [31:0]      wdata_i,
   output logic [31:0]      rdata_o,
   input  logic             fault_set_i,
   input  logic [VPN_W-1:0] fault_vpn_i,
   output logic             en_o,
   output logic             gate_o,
   output logic             bypass_o,
   output logic [VPN_W-1:0] first_vpn_o,
   output logic [VPN_W-1:0] vpn_range_o,
   output logic [PPN_W-1:0] base_ppn_o,
   output logic [PPN_W-1:0] dflt_rd_o,
   output logic [PPN_W-1:0] dflt_wr_o,
   output logic             flush_o
);
   localparam logic [7:0] OFF_VER   = 8'h00;
   localparam logic [7:0] OFF_CFG   = (LAYOUT == 1) ? 8'h04 : 8'h00;
   localparam logic [7:0] OFF_UPD   = (LAYOUT == 1) ? 8'h08 : 8'h04;
   localparam logic [7:0] OFF_FIRST = (LAYOUT == 1) ? 8'h1C : 8'h08;
   localparam logic [7:0] OFF_RANGE = (LAYOUT == 1) ? 8'h20 : 8'h0C;
   localparam logic [7:0] OFF_BASE  = 8'h10;
   localparam logic [7:0] OFF_DRD   = 8'h14;
   localparam logic [7:0] OFF_DWR   = 8'h18;
   localparam logic [7:0] OFF_AUTH  = 8'h0C;
   localparam logic [7:0] OFF_FLAG  = 8'h24;
   localparam logic [7:0] OFF_FVPN  = 8'h28;
   localparam logic [7:0] VER_CODE  = 8'(LAYOUT);

   logic             flag_q;
   logic [VPN_W-1:0] fvpn_q;
   logic [31:0]      auth_rd;
   logic [PPN_W-1:0] dwr_rd;

   assign flush_o = we_i && (addr_i == OFF_UPD) && (wdata_i == FLUSH_KEY);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_o        <= 1'b0;
         gate_o      <= 1'b0;
         bypass_o    <= 1'b0;
         first_vpn_o <= '0;
         vpn_range_o <= '0;
         base_ppn_o  <= '0;
         dflt_rd_o   <= '0;
         flag_q      <= 1'b0;
         fvpn_q      <= '0;
      end else begin
         if (we_i) begin
            if (addr_i == OFF_CFG) begin
               en_o     <= wdata_i[0];
               gate_o   <= wdata_i[1];
               bypass_o <= wdata_i[4];
            end
            if (addr_i == OFF_FIRST) first_vpn_o <= wdata_i[VPN_W-1:0];
            if (addr_i == OFF_RANGE) vpn_range_o <= wdata_i[VPN_W-1:0];
            if (addr_i == OFF_BASE)  base_ppn_o  <= wdata_i[PPN_W-1:0];
            if (addr_i == OFF_DRD)   dflt_rd_o   <= wdata_i[PPN_W-1:0];
         end
         if (fault_set_i) begin
            flag_q <= 1'b1;
            fvpn_q <= fault_vpn_i;
         end else if (we_i && addr_i == OFF_FLAG && wdata_i[0]) begin
            flag_q <= 1'b0;
         end
      end
   end

   generate
      if (LAYOUT == 1) begin : g_ext
         logic [31:0]      auth_q;
         logic [PPN_W-1:0] dwr_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               auth_q <= '0;
               dwr_q  <= '0;
            end else if (we_i) begin
               if (addr_i == OFF_AUTH) auth_q <= wdata_i;
               if (addr_i == OFF_DWR)  dwr_q  <= wdata_i[PPN_W-1:0];
            end
         end
         assign auth_rd   = auth_q;
         assign dwr_rd    = dwr_q;
         assign dflt_wr_o = dwr_q;
      end else begin : g_cmp
         assign auth_rd   = '0;
         assign dwr_rd    = '0;
         assign dflt_wr_o = dflt_rd_o;
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      if (addr_i == OFF_VER) rdata_o[15:8] = VER_CODE;
      if (addr_i == OFF_CFG) begin
         rdata_o[0] = en_o;
         rdata_o[1] = gate_o;
         rdata_o[4] = bypass_o;
      end
      if (addr_i == OFF_FIRST) rdata_o = 32'(first_vpn_o);
      if (addr_i == OFF_RANGE) rdata_o = 32'(vpn_range_o);
      if (addr_i == OFF_BASE)  rdata_o = 32'(base_ppn_o);
      if (addr_i == OFF_DRD)   rdata_o = 32'(dflt_rd_o);
      if (LAYOUT == 1 && addr_i == OFF_DWR)  rdata_o = 32'(dwr_rd);
      if (LAYOUT == 1 && addr_i == OFF_AUTH) rdata_o = auth_rd;
      if (addr_i == OFF_FLAG)  rdata_o = {31'b0, flag_q};
      if (addr_i == OFF_FVPN)  rdata_o = 32'(fvpn_q);
   end

   // R11: the flag only falls through an explicit clear
   a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q && !(we_i && addr_i == OFF_FLAG && wdata_i[0]) |=> flag_q);
endmodule

// File: rtl/flatmap_tlb.sv
module flatmap_tlb #(
   parameter int N     = 4,
   parameter int VPN_W = 20,
   parameter int PPN_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VPN_W-1:0] lookup_vpn_i,
   output logic             hit_o,
   output logic [PPN_W-1:0] hit_ppn_o,
   input  logic             fill_i,
   input  logic [VPN_W-1:0] fill_vpn_i,
   input  logic [PPN_W-1:0] fill_ppn_i,
   input  logic             flush_i
);
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

   logic [N-1:0]     valid_q;
   logic [N-1:0]     hit_vec;
   logic [VPN_W-1:0] tag_q [N];
   logic [PPN_W-1:0] ppn_q [N];
   logic [IDX_W-1:0] ptr_q;

   generate
      for (genvar g = 0; g < N; g++) begin : g_cmp
         assign hit_vec[g] = valid_q[g] && (tag_q[g] == lookup_vpn_i);
      end
   endgenerate

   assign hit_o = |hit_vec;

   always_comb begin
      hit_ppn_o = '0;
      for (int i = 0; i < N; i++) begin
         if (hit_vec[i]) hit_ppn_o = hit_ppn_o | ppn_q[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         ptr_q   <= '0;
      end else if (flush_i) begin
         valid_q <= '0;
      end else if (fill_i) begin
         valid_q[ptr_q] <= 1'b1;
         ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_i && !flush_i) begin
         tag_q[ptr_q] <= fill_vpn_i;
         ppn_q[ptr_q] <= fill_ppn_i;
      end
   end

   // R10: fills only on misses, so no VPN is held twice
   a_r10_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
   // R9: nothing survives a flush
   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !hit_o);
endmodule

// File: rtl/flatmap_iommu.sv
module flatmap_iommu
   import flatmap_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PA_W   = 32,
   parameter int TLB_N  = 4,
   parameter int LAYOUT = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_we,
   input  logic [7:0]      reg_addr,
   input  logic [31:0]     reg_wdata,
   output logic [31:0]     reg_rdata,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_va,
   input  logic            req_write,
   output logic            resp_valid,
   output logic [PA_W-1:0] resp_pa,
   output logic            resp_fault,
   output logic            mem_req_valid,
   input  logic            mem_req_ready,
   output logic [PA_W-1:0] mem_req_addr,
   input  logic            mem_rsp_valid,
   input  logic [31:0]     mem_rsp_data
);
   localparam int VPN_W = VA_W - PAGE_SHIFT;
   localparam int PPN_W = PA_W - PAGE_SHIFT;

   generate
      if (VA_W <= PAGE_SHIFT || VA_W > PA_W) begin : g_bad_va
         $error("flatmap_iommu: VA_W must exceed 12 and not exceed PA_W");
      end
      if (PA_W > 32) begin : g_bad_pa
         $error("flatmap_iommu: PA_W above 32 does not fit a table word");
      end
      if (TLB_N < 1) begin : g_bad_n
         $error("flatmap_iommu: TLB_N must be at least 1");
      end
      if (LAYOUT != 0 && LAYOUT != 1) begin : g_bad_layout
         $error("flatmap_iommu: LAYOUT must be 0 or 1");
      end
   endgenerate

   walk_state_e state_q;
   logic cfg_en, cfg_gate, cfg_bypass, flush;
   logic [VPN_W-1:0] first_vpn, vpn_range;
   logic [PPN_W-1:0] base_ppn, dflt_rd, dflt_wr;

   logic [VPN_W-1:0] req_vpn, diff;
   logic [PAGE_SHIFT-1:0] req_off;
   logic in_win, xl_on, fire;
   logic tlb_hit, tlb_fill;
   logic [PPN_W-1:0] tlb_ppn, rsp_ppn;

   logic [VPN_W-1:0] held_vpn, held_diff;
   logic [PAGE_SHIFT-1:0] held_off;
   logic held_wr;

   logic idle_walk, idle_fault;
   logic [PA_W-1:0] idle_pa;
   logic [VPN_W-1:0] resp_vpn_q;

   assign req_vpn = req_va[VA_W-1:PAGE_SHIFT];
   assign req_off = req_va[PAGE_SHIFT-1:0];
   assign diff    = req_vpn - first_vpn;
   assign in_win  = (req_vpn >= first_vpn) && (diff <= vpn_range);
   assign xl_on   = cfg_en && cfg_gate;
   assign req_ready = (state_q == WALK_IDLE);
   assign fire    = req_valid && req_ready;
   assign rsp_ppn = mem_rsp_data[PPN_W-1:0];
   assign tlb_fill = (state_q == WALK_WAIT) && mem_rsp_valid && (mem_rsp_data != 32'h0);
   assign mem_req_valid = (state_q == WALK_REQ);
   assign mem_req_addr  = {base_ppn, {PAGE_SHIFT{1'b0}}} + PA_W'({held_diff, 2'b00});

   flatmap_regs #(.LAYOUT(LAYOUT), .VPN_W(VPN_W), .PPN_W(PPN_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
      .wdata_i(reg_wdata), .rdata_o(reg_rdata),
      .fault_set_i(resp_valid && resp_fault), .fault_vpn_i(resp_vpn_q),
      .en_o(cfg_en), .gate_o(cfg_gate), .bypass_o(cfg_bypass),
      .first_vpn_o(first_vpn), .vpn_range_o(vpn_range), .base_ppn_o(base_ppn),
      .dflt_rd_o(dflt_rd), .dflt_wr_o(dflt_wr), .flush_o(flush)
   );

   flatmap_tlb #(.N(TLB_N), .VPN_W(VPN_W), .PPN_W(PPN_W)) tlb_i (
      .clk(clk), .rst_n(rst_n), .lookup_vpn_i(req_vpn),
      .hit_o(tlb_hit), .hit_ppn_o(tlb_ppn),
      .fill_i(tlb_fill), .fill_vpn_i(held_vpn), .fill_ppn_i(rsp_ppn),
      .flush_i(flush)
   );

   always_comb begin
      idle_walk  = 1'b0;
      idle_fault = 1'b0;
      idle_pa    = PA_W'(req_va);
      if (!cfg_bypass) begin
         if (!xl_on || !in_win) begin
            idle_fault = 1'b1;
            idle_pa    = {(req_write ? dflt_wr : dflt_rd), req_off};
         end else if (tlb_hit) begin
            idle_pa    = {tlb_ppn, req_off};
         end else begin
            idle_walk  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= WALK_IDLE;
         resp_valid <= 1'b0;
         resp_fault <= 1'b0;
         resp_pa    <= '0;
         resp_vpn_q <= '0;
         held_vpn   <= '0;
         held_diff  <= '0;
         held_off   <= '0;
         held_wr    <= 1'b0;
      end else begin
         resp_valid <= 1'b0;
         case (state_q)
            WALK_IDLE: if (fire) begin
               held_vpn  <= req_vpn;
               held_diff <= diff;
               held_off  <= req_off;
               held_wr   <= req_write;
               if (idle_walk) begin
                  state_q <= WALK_REQ;
               end else begin
                  resp_valid <= 1'b1;
                  resp_pa    <= idle_pa;
                  resp_fault <= idle_fault;
                  resp_vpn_q <= req_vpn;
               end
            end
            WALK_REQ: if (mem_req_ready) state_q <= WALK_WAIT;
            WALK_WAIT: if (mem_rsp_valid) begin
               state_q    <= WALK_IDLE;
               resp_valid <= 1'b1;
               resp_vpn_q <= held_vpn;
               if (mem_rsp_data == 32'h0) begin
                  resp_fault <= 1'b1;
                  resp_pa    <= {(held_wr ? dflt_wr : dflt_rd), held_off};
               end else begin
                  resp_fault <= 1'b0;
                  resp_pa    <= {rsp_ppn, held_off};
               end
            end
            default: state_q <= WALK_IDLE;
         endcase
      end
   end

   // R8: one table read per miss
   a_r8_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_ready |=> !mem_req_valid);
   // R3: out-of-window requests answer at once with a fault and no walk
   a_r3_outside_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !cfg_bypass && !in_win |=> !mem_req_valid && resp_valid && resp_fault);
   // R6: bypass returns the request address unchanged
   a_r6_bypass_identity: assert property (@(posedge clk) disable iff (!rst_n)
      fire && cfg_bypass |=> resp_valid && !resp_fault && resp_pa == PA_W'($past(req_va)));
   // R5: a zero table word always faults
   a_r5_zero_entry: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == WALK_WAIT && mem_rsp_valid && mem_rsp_data == 32'h0 |=> resp_valid && resp_fault);
endmodule

// File: tb/flatmap_iommu_tb_top.sv
`timescale 1ns/1ps
module flatmap_iommu_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_va = '0;
   logic        req_write = 1'b0;
   logic        resp_valid;
   logic [31:0] resp_pa;
   logic        resp_fault;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;

   int checks = 0;
   int errors = 0;
   int mem_reads = 0;
   logic [31:0] last_addr = '0;

   localparam logic [31:0] TBL = 32'h0004_0000;
   localparam logic [19:0] DRD = 20'h00AAA;
   localparam logic [19:0] DWR = 20'h00BBB;

   always #2.5 clk = ~clk;

   flatmap_iommu #(.VA_W(32), .PA_W(32), .TLB_N(4), .LAYOUT(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
      .req_ready(req_ready), .req_va(req_va), .req_write(req_write),
      .resp_valid(resp_valid), .resp_pa(resp_pa), .resp_fault(resp_fault),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data)
   );

   function automatic logic [31:0] ent(input int i);
      return (i == 5) ? 32'h0 : 32'h0003_0000 + 32'(i) * 3;
   endfunction

   // memory model: answers one cycle after the read handshake
   initial begin
      logic pend = 1'b0;
      forever begin
         @(negedge clk);
         if (pend) begin
            mem_rsp_valid = 1'b1;
            if (last_addr >= TBL && last_addr < TBL + 32'h20 && last_addr[1:0] == 2'b00)
               mem_rsp_data = ent(int'((last_addr - TBL) >> 2));
            else
               mem_rsp_data = 32'h0;
            pend = 1'b0;
         end else begin
            mem_rsp_valid = 1'b0;
         end
         if (mem_req_valid) begin
            last_addr = mem_req_addr;
            mem_reads++;
            pend = 1'b1;
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic do_req(input logic [31:0] va, input logic wr, output logic [31:0] pa,
                         output logic flt, output int lat, output int nrd, output logic busy);
      int r0;
      r0 = mem_reads;
      busy = 1'b0;
      @(negedge clk);
      req_va = va; req_write = wr; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!resp_valid && lat < 50) begin
         if (!req_ready) busy = 1'b1;
         @(negedge clk);
         lat++;
      end
      pa = resp_pa; flt = resp_fault; nrd = mem_reads - r0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d, pa;
      logic flt, busy;
      int lat, nrd;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R7 reset state and version
      rd_reg(8'h00, d); check("R7 version", d, 32'h0000_0100);
      rd_reg(8'h04, d); check("R6 cfg reset", d, 32'h0);
      rd_reg(8'h24, d); check("R11 flag reset", d, 32'h0);
      check("R12 ready after reset", 32'(req_ready), 32'h1);
      check("R8 no read after reset", 32'(mem_req_valid), 32'h0);

      wr_reg(8'h14, 32'(DRD));
      wr_reg(8'h18, 32'(DWR));
      wr_reg(8'h10, TBL >> 12);
      wr_reg(8'h1C, 32'h10);
      wr_reg(8'h20, 32'h7);
      wr_reg(8'h0C, 32'h5A5A_1234);
      rd_reg(8'h14, d); check("R7 read fallback", d, 32'(DRD));
      rd_reg(8'h18, d); check("R7 write fallback", d, 32'(DWR));
      rd_reg(8'h10, d); check("R7 table base", d, 32'h40);
      rd_reg(8'h1C, d); check("R7 first vpn", d, 32'h10);
      rd_reg(8'h20, d); check("R7 range", d, 32'h7);
      rd_reg(8'h0C, d); check("R7 auth", d, 32'h5A5A_1234);

      // R6/R4 translation off: fallback by direction
      do_req(32'h0001_1234, 1'b0, pa, flt, lat, nrd, busy);
      check("R6 off read fault", 32'(flt), 32'h1);
      check("R4 off read fallback", pa, {DRD, 12'h234});
      do_req(32'h0001_1234, 1'b1, pa, flt, lat, nrd, busy);
      check("R4 off write fallback", pa, {DWR, 12'h234});
      wr_reg(8'h04, 32'h1);
      do_req(32'h0001_1234, 1'b0, pa, flt, lat, nrd, busy);
      check("R6 gate clear faults", 32'(flt), 32'h1);
      check("R6 gate clear no read", 32'(nrd), 32'h0);
      wr_reg(8'h04, 32'h3);
      rd_reg(8'h04, d); check("R7 cfg readback", d, 32'h3);

      // R1/R2/R3/R4/R5 sweep around the window, both directions
      for (int v = 32'h0D; v <= 32'h1A; v++) begin
         for (int w = 0; w < 2; w++) begin
            logic [31:0] va, exp_pa;
            logic [11:0] off;
            logic exp_f;
            int i;
            off = 12'(v * 32'h13 + w * 32'h301);
            va = {20'(v), off};
            i = v - 32'h10;
            if (v < 32'h10 || v > 32'h17 || ent(i) == 32'h0) begin
               exp_f = 1'b1;
               exp_pa = {(w == 1) ? DWR : DRD, off};
            end else begin
               exp_f = 1'b0;
               exp_pa = {ent(i)[19:0], off};
            end
            do_req(va, w[0], pa, flt, lat, nrd, busy);
            check("R1 R3 R4 R5 sweep pa", pa, exp_pa);
            check("R3 R5 sweep fault", 32'(flt), 32'(exp_f));
            if (v < 32'h10 || v > 32'h17)
               check("R3 no read outside", 32'(nrd), 32'h0);
            else if (nrd != 0)
               check("R2 table address", last_addr, TBL + 32'(i) * 4);
         end
      end

      // R8 latencies, R12 busy during walk
      wr_reg(8'h08, 32'hFFFF_FFFF);
      do_req(32'h0001_1ABC, 1'b0, pa, flt, lat, nrd, busy);
      check("R8 miss latency", 32'(lat), 32'd3);
      check("R8 miss one read", 32'(nrd), 32'd1);
      check("R12 not ready during walk", 32'(busy), 32'h1);
      do_req(32'h0001_1ABD, 1'b0, pa, flt, lat, nrd, busy);
      check("R8 hit latency", 32'(lat), 32'd1);
      check("R8 hit no read", 32'(nrd), 32'd0);
      check("R1 hit pa", pa, {ent(1)[19:0], 12'hABD});

      // R9 only the key flushes
      wr_reg(8'h08, 32'h1234_5678);
      do_req(32'h0001_1000, 1'b0, pa, flt, lat, nrd, busy);
      check("R9 other value keeps cache", 32'(nrd), 32'd0);
      wr_reg(8'h08, 32'hFFFF_FFFF);
      do_req(32'h0001_1000, 1'b0, pa, flt, lat, nrd, busy);
      check("R9 key flushes", 32'(nrd), 32'd1);

      // R10 round robin
      wr_reg(8'h08, 32'hFFFF_FFFF);
      for (int p = 0; p < 5; p++) begin
         do_req({20'(32'h10 + p), 12'h0}, 1'b0, pa, flt, lat, nrd, busy);
         check("R10 fill miss", 32'(nrd), 32'd1);
      end
      do_req(32'h0001_1000, 1'b0, pa, flt, lat, nrd, busy);
      check("R10 second page kept", 32'(nrd), 32'd0);
      do_req(32'h0001_0000, 1'b0, pa, flt, lat, nrd, busy);
      check("R10 first page evicted", 32'(nrd), 32'd1);

      // R11 sticky flag
      wr_reg(8'h24, 32'h1);
      rd_reg(8'h24, d); check("R11 cleared", d, 32'h0);
      do_req(32'h0001_2000, 1'b0, pa, flt, lat, nrd, busy);
      rd_reg(8'h24, d); check("R11 clean access leaves flag", d, 32'h0);
      do_req(32'h0001_F777, 1'b1, pa, flt, lat, nrd, busy);
      rd_reg(8'h24, d); check("R11 fault sets flag", d, 32'h1);
      rd_reg(8'h28, d); check("R11 fault vpn", d, 32'h1F);
      wr_reg(8'h24, 32'h0);
      rd_reg(8'h24, d); check("R11 zero write keeps flag", d, 32'h1);

      // R3 window at the top of the VPN space
      wr_reg(8'h08, 32'hFFFF_FFFF);
      wr_reg(8'h1C, 32'hFFFFE);
      do_req(32'h0000_1456, 1'b0, pa, flt, lat, nrd, busy);
      check("R3 no wrap alias fault", 32'(flt), 32'h1);
      check("R3 no wrap alias read", 32'(nrd), 32'd0);
      do_req(32'hFFFF_F456, 1'b0, pa, flt, lat, nrd, busy);
      check("R3 top page translated", pa, {ent(1)[19:0], 12'h456});
      check("R2 top page address", last_addr, TBL + 32'h4);
      do_req(32'hFFFF_D456, 1'b1, pa, flt, lat, nrd, busy);
      check("R3 below first faults", pa, {DWR, 12'h456});

      // R6 bypass priority
      wr_reg(8'h04, 32'h13);
      do_req(32'hDEAD_BEEF, 1'b0, pa, flt, lat, nrd, busy);
      check("R6 bypass pa", pa, 32'hDEAD_BEEF);
      check("R6 bypass no fault", 32'(flt), 32'h0);
      check("R6 bypass no read", 32'(nrd), 32'd0);
      wr_reg(8'h04, 32'h10);
      do_req(32'h0123_4567, 1'b1, pa, flt, lat, nrd, busy);
      check("R6 bypass while off", pa, 32'h0123_4567);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule